// File: doc/BRIEF.md
# Presettable Binary/Decade Up/Down Counter

This block is a synchronous counter built from a chain of four-bit digits that share one clock. Each digit counts either in plain binary (0 to 15) or in BCD (0 to 9). A run-time select chooses the radix and another selects the direction. The whole chain advances on the rising clock edge. An active-low carry input acts as the clock enable. A combinational, active-low carry output marks the cycle in which the chain stands at its last value in the chosen direction. Several instances can therefore be chained by wiring one carry output to the next carry input.

A level-sensitive preset loads a jam value into every digit without waiting for a clock edge. While the preset is held, the count follows the jam inputs. After the preset is released, the count keeps the loaded value until the next enabled edge. A synchronous active-high reset clears the count. Inside the block the digits are linked by a look-ahead enable chain. Digit k therefore advances in the same edge as digit 0 when every digit below it is at its terminal value.

Top module: `presettable_tally`

## Requirements
- R1: While `preset` is high, `count` equals `jam` at all times, with no clock edge needed. A `jam` of all zeros gives a count of zero.
- R2: A clock edge with `preset` high does not count; it reloads `jam`. After `preset` falls, with `jam` held steady around the release, the count keeps that value until the first edge at which `carry_in_n` and `preset` are both low.
- R3: The count changes on a rising `clk` edge only when `carry_in_n` is low and `preset` is low at that edge; otherwise it holds.
- R4: With `bin_mode` = 1, each digit runs over 0..15. Counting up wraps 15 to 0, and counting down wraps 0 to 15.
- R5: With `bin_mode` = 0, counting up wraps 9 to 0 and counting down wraps 0 to 9. A digit loaded with 10..15 steps to 0 when counting up and to its value minus one when counting down.
- R6: Digit k occupies bits [4k+3:4k], with digit 0 the least significant. Digit k+1 advances on an enabled edge exactly when every lower digit is at its terminal value: 15 (binary) or 9 (decade) when counting up, 0 when counting down. The whole count therefore behaves as one multi-digit hexadecimal or BCD counter.
- R7: `carry_out_n` is low exactly when `carry_in_n` is low and every digit of the displayed count is at its terminal value. It is combinational, follows the jam value during preset, and is high otherwise.
- R8: `rst` high at a rising edge with `preset` low clears the count to zero.
- R9: Changes of `bin_mode` or `count_up` take effect on the next enabled edge without any reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, rising edge |
| rst | input | 1 | Synchronous active-high clear |
| carry_in_n | input | 1 | Active-low count enable / cascade carry in |
| bin_mode | input | 1 | 1 = binary digits, 0 = BCD digits |
| count_up | input | 1 | 1 = count up, 0 = count down |
| preset | input | 1 | Level-sensitive asynchronous load of `jam` |
| jam | input | 4*STAGES | Value loaded by preset, digit 0 in bits [3:0] |
| count | output | 4*STAGES | Current count |
| carry_out_n | output | 1 | Active-low terminal-count carry to the next stage |

## Verification
The bench builds the block with STAGES = 2. This gives 256 states in binary and 100 valid states in BCD. Each radix-and-direction pair can therefore be swept through every state, including the wrap of the whole chain and every digit-to-digit carry, in a few hundred cycles. A long random run then mixes presets of arbitrary jam values (including non-BCD digits), enable gaps, resets and mid-run changes of radix and direction. Every cycle of that run is compared with an arithmetic digit model. Between edges the bench also checks the count and carry output, to cover the asynchronous preset and the combinational carry.

// File: rtl/tally_pkg.sv
package tally_pkg;

    localparam int DIGIT_W = 4;

    typedef logic [DIGIT_W-1:0] digit_t;

    typedef enum logic {
        RADIX_DEC = 1'b0,
        RADIX_BIN = 1'b1
    } radix_e;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

    typedef struct packed {
        radix_e radix;
        dir_e   dir;
    } mode_t;

    // Largest legal digit value for the selected radix.
    function automatic digit_t top_value(input radix_e r);
        return (r == RADIX_BIN) ? digit_t'(15) : digit_t'(9);
    endfunction

    // Digit stands at the last value before a wrap in the chosen direction.
    function automatic logic is_terminal(input digit_t d, input mode_t m);
        if (m.dir == DIR_UP)
            return d == top_value(m.radix);
        else
            return d == '0;
    endfunction

    // One count step for a single digit; non-BCD values step up to zero.
    function automatic digit_t step_digit(input digit_t d, input mode_t m);
        digit_t lim;
        lim = top_value(m.radix);
        if (m.dir == DIR_UP)
            return (d >= lim) ? '0 : d + digit_t'(1);
        else
            return (d == '0) ? lim : d - digit_t'(1);
    endfunction

endpackage

// File: rtl/tally_lookahead.sv
module tally_lookahead #(
    parameter int STAGES = 2
) (
    input  logic              carry_in_n,
    input  logic              preset,
    input  logic [STAGES-1:0] term,
    output logic [STAGES-1:0] adv,
    output logic              carry_out_n
);

    // chain[k] is high when the chain is enabled and digits 0..k-1 are terminal
    logic [STAGES:0] chain;

    assign chain[0] = ~carry_in_n;

    for (genvar k = 0; k < STAGES; k++) begin : g_chain
        assign chain[k+1] = chain[k] & term[k];
        assign adv[k]     = chain[k] & ~preset;
    end

    assign carry_out_n = ~chain[STAGES];

endmodule

// File: rtl/tally_digit.sv
module tally_digit
    import tally_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   preset,
    input  logic   adv,
    input  mode_t  mode,
    input  digit_t jam_d,
    output digit_t shown,
    output logic   at_term
);

    digit_t held;

    // Preset loads asynchronously and keeps reloading while held high.
    always_ff @(posedge clk or posedge preset) begin
        if (preset)
            held <= jam_d;
        else if (rst)
            held <= '0;
        else if (adv)
            held <= step_digit(held, mode);
    end

    // While preset is high the jam value is passed straight through.
    assign shown   = preset ? jam_d : held;
    assign at_term = is_terminal(shown, mode);

endmodule

// File: rtl/presettable_tally.sv
module presettable_tally
    import tally_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      carry_in_n,
    input  logic                      bin_mode,
    input  logic                      count_up,
    input  logic                      preset,
    input  logic [DIGIT_W*STAGES-1:0] jam,
    output logic [DIGIT_W*STAGES-1:0] count,
    output logic                      carry_out_n
);

    localparam int W = DIGIT_W * STAGES;

    mode_t             mode;
    logic [STAGES-1:0] term;
    logic [STAGES-1:0] adv;

    always_comb begin
        mode.radix = radix_e'(bin_mode);
        mode.dir   = dir_e'(count_up);
    end

    tally_lookahead #(
        .STAGES (STAGES)
    ) u_lookahead (
        .carry_in_n  (carry_in_n),
        .preset      (preset),
        .term        (term),
        .adv         (adv),
        .carry_out_n (carry_out_n)
    );

    for (genvar k = 0; k < STAGES; k++) begin : g_digit
        tally_digit u_digit (
            .clk     (clk),
            .rst     (rst),
            .preset  (preset),
            .adv     (adv[k]),
            .mode    (mode),
            .jam_d   (jam[k*DIGIT_W +: DIGIT_W]),
            .shown   (count[k*DIGIT_W +: DIGIT_W]),
            .at_term (term[k])
        );
    end

    logic [W-1:0] unused_w;
    assign unused_w = '0;

endmodule

// File: rtl/tally_checker.sv
module tally_checker #(
    parameter int STAGES = 2
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  carry_in_n,
    input logic                  bin_mode,
    input logic                  count_up,
    input logic                  preset,
    input logic [4*STAGES-1:0]   jam,
    input logic [4*STAGES-1:0]   count,
    input logic                  carry_out_n
);

    localparam int W = 4 * STAGES;

    // R1: count mirrors jam while preset is high
    p_preset_follows_r1: assert property (@(posedge clk) disable iff (rst)
        preset |-> (count == jam));

    // R3: disabled edge leaves the count unchanged
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (carry_in_n && !preset) |=> (preset || count == $past(count)));

    // R4: binary digit 0 wraps 15 -> 0 counting up
    p_bin_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (!preset && !carry_in_n && bin_mode && count_up && count[3:0] == 4'hF)
        |=> (preset || count[3:0] == 4'h0));

    // R5: decade digit 0 wraps 0 -> 9 counting down
    p_dec_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (!preset && !carry_in_n && !bin_mode && !count_up && count[3:0] == 4'h0)
        |=> (preset || count[3:0] == 4'h9));

    // R5: non-BCD digit 0 steps to zero counting up
    p_dec_invalid_r5: assert property (@(posedge clk) disable iff (rst)
        (!preset && !carry_in_n && !bin_mode && count_up && count[3:0] > 4'h9)
        |=> (preset || count[3:0] == 4'h0));

    // R7: carry out can only be low with carry in low
    p_carry_gate_r7: assert property (@(posedge clk) disable iff (rst)
        !carry_out_n |-> !carry_in_n);

    // R7: full binary count counting up raises the carry
    p_carry_full_r7: assert property (@(posedge clk) disable iff (rst)
        (!carry_in_n && bin_mode && count_up && count == {W{1'b1}})
        |-> !carry_out_n);

    if (STAGES > 1) begin : g_upper
        // R6: upper digits hold while digit 0 is not at its terminal value
        p_upper_hold_r6: assert property (@(posedge clk) disable iff (rst)
            (!preset && !carry_in_n && bin_mode && count_up && count[3:0] != 4'hF)
            |=> (preset || count[W-1:4] == $past(count[W-1:4])));
    end

endmodule

bind presettable_tally tally_checker #(
    .STAGES (STAGES)
) u_tally_chk (
    .clk         (clk),
    .rst         (rst),
    .carry_in_n  (carry_in_n),
    .bin_mode    (bin_mode),
    .count_up    (count_up),
    .preset      (preset),
    .jam         (jam),
    .count       (count),
    .carry_out_n (carry_out_n)
);

// File: tb/presettable_tally_bench.sv
module presettable_tally_bench;

    localparam int ST = 2;
    localparam int W  = 4 * ST;
    localparam int WATCHDOG_CYCLES = 200000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         carry_in_n = 1'b1;
    logic         bin_mode = 1'b1;
    logic         count_up = 1'b1;
    logic         preset = 1'b0;
    logic [W-1:0] jam = '0;
    logic [W-1:0] count;
    logic         carry_out_n;

    logic [W-1:0] mdl = '0;
    int           errors = 0;
    int           checks = 0;
    bit           done = 0;

    always #2 clk = ~clk;

    presettable_tally #(.STAGES(ST)) u_presettable_tally (
        .clk (clk), .rst (rst), .carry_in_n (carry_in_n), .bin_mode (bin_mode),
        .count_up (count_up), .preset (preset), .jam (jam), .count (count),
        .carry_out_n (carry_out_n)
    );

    function automatic logic [3:0] ref_step(input logic [3:0] d, input logic bm, input logic up);
        int lim;
        lim = bm ? 15 : 9;
        if (up) return (int'(d) >= lim) ? 4'd0 : d + 4'd1;
        else    return (d == 4'd0) ? 4'(lim) : d - 4'd1;
    endfunction

    function automatic logic ref_term(input logic [3:0] d, input logic bm, input logic up);
        if (up) return d == (bm ? 4'd15 : 4'd9);
        else    return d == 4'd0;
    endfunction

    function automatic logic [W-1:0] shown_val();
        return preset ? jam : mdl;
    endfunction

    function automatic logic ref_cout();
        logic [W-1:0] s;
        logic all_t;
        s = shown_val();
        all_t = 1'b1;
        for (int k = 0; k < ST; k++) all_t &= ref_term(s[4*k +: 4], bin_mode, count_up);
        return !(!carry_in_n && all_t);
    endfunction

    task automatic model_edge();
        logic go;
        logic [W-1:0] nxt;
        if (preset) mdl = jam;
        else if (rst) mdl = '0;
        else begin
            go  = !carry_in_n;
            nxt = mdl;
            for (int k = 0; k < ST; k++) begin
                if (go) nxt[4*k +: 4] = ref_step(mdl[4*k +: 4], bin_mode, count_up);
                go = go && ref_term(mdl[4*k +: 4], bin_mode, count_up);
            end
            mdl = nxt;
        end
    endtask

    task automatic check_val(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_outputs(input string tag);
        check_val(tag, count, shown_val());
        check_val({tag, " carry"}, W'(carry_out_n), W'(ref_cout()));
    endtask

    task automatic drive(input logic r, input logic cin, input logic bm, input logic up,
                         input logic pre, input logic [W-1:0] j);
        @(negedge clk);
        rst = r; carry_in_n = cin; bin_mode = bm; count_up = up; preset = pre; jam = j;
        #1;
    endtask

    task automatic tick(input string tag);
        @(posedge clk);
        model_edge();
        #1;
        check_outputs(tag);
    endtask

    task automatic load(input logic bm, input logic up, input logic [W-1:0] v);
        drive(0, 1, bm, up, 1, v);
        drive(0, 1, bm, up, 0, v);
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        // R8: reset clears
        tick("R8 reset");
        tick("R8 reset");
        check_val("R8 zero", count, '0);

        // R1: asynchronous follow, no clock edge between changes
        drive(0, 1, 1, 1, 1, 8'h37);
        check_val("R1 load", count, 8'h37);
        #1 jam = 8'h5A; #1;
        check_val("R1 follow", count, 8'h5A);
        #1 jam = 8'h00; #1;
        check_val("R1 zero", count, 8'h00);

        // R2: edge during preset reloads, release keeps value
        drive(0, 0, 1, 1, 1, 8'h42);
        tick("R2 edge under preset");
        drive(0, 1, 1, 1, 0, 8'h42);
        check_val("R2 release", count, 8'h42);
        // R3: disabled edge holds
        tick("R3 hold");
        check_val("R3 hold value", count, 8'h42);
        drive(0, 0, 1, 1, 0, 8'h42);
        tick("R3 count");
        check_val("R3 advanced", count, 8'h43);

        // R7: combinational carry at terminal values
        drive(0, 0, 0, 1, 1, 8'h99);
        check_val("R7 dec up 99", W'(carry_out_n), W'(0));
        drive(0, 1, 0, 1, 1, 8'h99);
        check_val("R7 gated by carry in", W'(carry_out_n), W'(1));
        drive(0, 0, 0, 0, 1, 8'h00);
        check_val("R7 down 00", W'(carry_out_n), W'(0));
        drive(0, 0, 0, 1, 1, 8'hFF);
        check_val("R7 dec FF not terminal", W'(carry_out_n), W'(1));
        drive(0, 0, 1, 1, 1, 8'hFF);
        check_val("R7 bin up FF", W'(carry_out_n), W'(0));

        // R5: non-BCD digits
        load(0, 1, 8'h0C); mdl = 8'h0C;
        drive(0, 0, 0, 1, 0, 8'h0C);
        tick("R5 invalid up");
        check_val("R5 0C up", count, 8'h00);
        load(0, 0, 8'h0C); mdl = 8'h0C;
        drive(0, 0, 0, 0, 0, 8'h0C);
        tick("R5 invalid down");
        check_val("R5 0C down", count, 8'h0B);
        load(0, 1, 8'hB9); mdl = 8'hB9;
        drive(0, 0, 0, 1, 0, 8'hB9);
        tick("R5 invalid upper");
        check_val("R5 B9 up", count, 8'h00);

        // R4/R5/R6: full sweeps over each radix and direction
        for (int bm = 0; bm < 2; bm++) begin
            for (int up = 0; up < 2; up++) begin
                load(bm[0], up[0], 8'h00); mdl = 8'h00;
                drive(0, 0, bm[0], up[0], 0, 8'h00);
                for (int c = 0; c < 270; c++)
                    tick(bm ? "R4 R6 binary sweep" : "R5 R6 decade sweep");
            end
        end

        // R9 and mixed: random sequences of mode, direction, enable, preset, reset
        for (int c = 0; c < 4000; c++) begin
            logic r, cin, bm, up, pre;
            logic [W-1:0] j;
            r   = ($urandom_range(63) == 0);
            cin = ($urandom_range(3) == 0);
            bm  = ($urandom_range(31) == 0) ? ~bin_mode : bin_mode;
            up  = ($urandom_range(31) == 0) ? ~count_up : count_up;
            j   = jam;
            if (preset) pre = ($urandom_range(1) == 0);
            else begin
                pre = ($urandom_range(15) == 0);
                if (pre) j = W'($urandom);
            end
            drive(r, cin, bm, up, pre, j);
            check_outputs("R9 R1 between edges");
            tick("R9 R6 random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule